// File: doc/BRIEF.md
# MII Transmit Frame Generator

This block turns a host payload byte stream into a complete Ethernet frame on a 4-bit MII transmit interface. The host pulses a start strobe with the destination address, source address and length/type value. It then streams the payload bytes over a valid/ready handshake and marks the final byte. The block adds the preamble and start delimiter, pads a short payload with zero bytes up to the minimum data length, and appends a CRC-32 frame check sequence. The CRC covers the header, data and pad bytes. Every nibble goes out on consecutive clocks, with the transmit enable held high for the whole frame.

The payload side is a valid/ready stream. A byte moves on a clock edge where both `s_valid` and `s_ready` are high. `s_ready` is independent of `s_valid`. It opens only while a frame is in progress and closes once the final byte has been taken. The block keeps a single byte in hand. Because the wire cannot stall, the host must keep pace with one byte every two clocks once the data field starts. A byte that is missing when its slot comes up aborts the frame. A payload that runs past the maximum data length also aborts it. After every frame, whether finished or aborted, the line stays quiet for the interframe gap before the next start is taken. Every frame carries at least one payload byte.

Top module: `mii_frame_tx`

## Requirements
- R1: After reset `mii_tx_en`, `mii_txd`, `s_ready` and `tx_err` are all low and `idle` is high.
- R2: A start sampled high while `idle` is high raises `mii_tx_en` on the next clock. The frame opens with PRE_BYTES bytes of 0x55 and then one byte of 0xD5. Every byte of the frame goes out low nibble first, with bit 0 of each nibble on `mii_txd[0]`.
- R3: After the delimiter come 14 header bytes: `dst_mac`, then `src_mac`, then `len_type`, each most significant byte first, all captured when the start is accepted.
- R4: Payload bytes taken on edges where `s_valid` and `s_ready` are both high are sent in order right after the header. `s_ready` stays low while `idle` is high.
- R5: A payload shorter than MIN_DATA bytes is followed by zero bytes until the data field holds exactly MIN_DATA bytes. A payload of MIN_DATA or more bytes gets no pad.
- R6: After the data field come four FCS bytes, least significant byte first. The FCS is the CRC-32 with reflected polynomial 0xEDB88320, initial value 0xFFFFFFFF and final inversion, taken over the header, data and pad bytes.
- R7: If a byte is pending when the slot for data byte number MAX_DATA+1 comes up, `mii_tx_en` is low in that cycle, `tx_err` is high for that one cycle, and no FCS is sent.
- R8: If no byte is pending when a data slot comes up before the final byte has been sent, the frame is aborted in the same way as in R7.
- R9: After the last nibble of a frame, or after an abort, `mii_tx_en` stays low for at least IFG_NIB clocks. With start held high, exactly IFG_NIB+1 low clocks separate two frames.
- R10: A start strobe while `idle` is low has no effect on the frame in progress.
- R11: `mii_tx_en` stays high without a break from the first preamble nibble to the last FCS nibble. This is 2*(PRE_BYTES+1+14+max(n,MIN_DATA)+4) clocks for an n-byte payload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Nibble clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a frame; taken only while idle |
| dst_mac | input | 48 | Destination address, captured at start |
| src_mac | input | 48 | Source address, captured at start |
| len_type | input | 16 | Length/type value, captured at start |
| idle | output | 1 | High when a start would be accepted |
| s_valid | input | 1 | Payload byte valid |
| s_data | input | 8 | Payload byte |
| s_last | input | 1 | Marks the final payload byte |
| s_ready | output | 1 | Block can take a payload byte this cycle |
| mii_txd | output | 4 | Transmit nibble |
| mii_tx_en | output | 1 | Transmit enable |
| tx_err | output | 1 | One-cycle pulse when a frame is aborted |

## Verification
The bench builds the block with MIN_DATA 46, PRE_BYTES 7 and IFG_NIB 24 as in the defaults. It lowers MAX_DATA to 64. With that limit the oversize abort is reached with a 70-byte payload, and a payload of exactly the limit is also tested, with no frame of 1500 bytes needed. The smaller limit also keeps every frame short. This leaves room for the pad boundary at exactly 46 bytes, a mid-frame stall that causes an underrun, a stray start during a frame, and a measured gap between back-to-back frames.

// File: rtl/mft_pkg.sv
package mft_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_SFD,
    ST_HDR,
    ST_DATA,
    ST_PAD,
    ST_FCS,
    ST_GAP
  } mft_state_e;

  localparam int HDR_BYTES = 14;
  localparam int FCS_NIB   = 8;
  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/mft_crc32.sv
module mft_crc32 #(
  parameter logic [31:0] POLY = 32'hEDB88320
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       init,
  input  logic       step,
  input  logic       shift,
  input  logic [3:0] nib,
  output logic [3:0] fcs_nib
);

  logic [31:0]      crc_q;
  logic [4:0][31:0] stage;

  assign stage[0] = crc_q;

  for (genvar k = 0; k < 4; k++) begin : g_bit
    assign stage[k+1] = (stage[k] >> 1) ^ ((stage[k][0] ^ nib[k]) ? POLY : 32'h0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      crc_q <= '1;
    else if (init)   crc_q <= '1;
    else if (step)   crc_q <= stage[4];
    else if (shift)  crc_q <= {4'hF, crc_q[31:4]};
  end

  assign fcs_nib = ~crc_q[3:0];

endmodule

// File: rtl/mft_hdr_shift.sv
module mft_hdr_shift #(
  parameter int BYTES = 14
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               advance,
  input  logic [BYTES*8-1:0] hdr,
  output logic [7:0]         cur_byte
);

  localparam int W = BYTES * 8;

  logic [W-1:0] sr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       sr_q <= '0;
    else if (load)    sr_q <= hdr;
    else if (advance) sr_q <= {sr_q[W-9:0], 8'h00};
  end

  assign cur_byte = sr_q[W-1 -: 8];

endmodule

// File: rtl/mft_byte_hold.sv
module mft_byte_hold (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       accept_en,
  input  logic       consume,
  input  logic       s_valid,
  input  logic [7:0] s_data,
  input  logic       s_last,
  output logic       s_ready,
  output logic       full,
  output logic [7:0] data,
  output logic       last
);

  logic last_taken_q;
  logic take;

  assign s_ready = accept_en && !last_taken_q && (!full || consume);
  assign take    = s_ready && s_valid;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      full         <= 1'b0;
      data         <= 8'h00;
      last         <= 1'b0;
      last_taken_q <= 1'b0;
    end else if (take) begin
      full         <= 1'b1;
      data         <= s_data;
      last         <= s_last;
      last_taken_q <= s_last;
    end else if (consume) begin
      full         <= 1'b0;
    end
  end

endmodule

// File: rtl/mii_frame_tx.sv
module mii_frame_tx
  import mft_pkg::*;
#(
  parameter int MIN_DATA  = 46,
  parameter int MAX_DATA  = 1500,
  parameter int PRE_BYTES = 7,
  parameter int IFG_NIB   = 24
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [47:0] dst_mac,
  input  logic [47:0] src_mac,
  input  logic [15:0] len_type,
  output logic        idle,
  input  logic        s_valid,
  input  logic [7:0]  s_data,
  input  logic        s_last,
  output logic        s_ready,
  output logic [3:0]  mii_txd,
  output logic        mii_tx_en,
  output logic        tx_err
);

  localparam int PRE_NIB = 2 * PRE_BYTES;
  localparam int HDR_NIB = 2 * HDR_BYTES;
  localparam int CNT_TOP = max_of(max_of(PRE_NIB, HDR_NIB), max_of(IFG_NIB, FCS_NIB));
  localparam int NW      = $clog2(CNT_TOP + 1);
  localparam int DW      = $clog2(MAX_DATA + 2);

  localparam logic [NW-1:0] PRE_END = NW'(PRE_NIB - 1);
  localparam logic [NW-1:0] HDR_END = NW'(HDR_NIB - 1);
  localparam logic [NW-1:0] FCS_END = NW'(FCS_NIB - 1);
  localparam logic [NW-1:0] GAP_END = NW'(IFG_NIB - 1);
  localparam logic [DW-1:0] PAD_END = DW'(MIN_DATA - 1);
  localparam logic [DW-1:0] D_LIMIT = DW'(MAX_DATA);

  mft_state_e    state_q;
  logic [NW-1:0] ncnt_q;
  logic [DW-1:0] dcnt_q;

  logic       start_ok, sending, abort_now, consume;
  logic       hold_full, hold_last, hold_clear, accept_en;
  logic [7:0] hold_data, hdr_byte;
  logic [3:0] cur_nib, fcs_nib;
  logic       crc_step, crc_shift;

  assign idle      = (state_q == ST_IDLE);
  assign start_ok  = idle && start;
  assign sending   = (state_q == ST_PRE) || (state_q == ST_SFD) || (state_q == ST_HDR) ||
                     (state_q == ST_DATA) || (state_q == ST_PAD) || (state_q == ST_FCS);
  assign abort_now = (state_q == ST_DATA) && !ncnt_q[0] && (!hold_full || dcnt_q == D_LIMIT);
  assign consume   = (state_q == ST_DATA) && ncnt_q[0];
  assign accept_en = (state_q == ST_PRE) || (state_q == ST_SFD) ||
                     (state_q == ST_HDR) || (state_q == ST_DATA);
  assign hold_clear = (state_q == ST_IDLE) || (state_q == ST_GAP);
  assign crc_step  = (state_q == ST_HDR) || (state_q == ST_PAD) ||
                     ((state_q == ST_DATA) && !abort_now);
  assign crc_shift = (state_q == ST_FCS);

  always_comb begin
    unique case (state_q)
      ST_PRE:  cur_nib = 4'h5;
      ST_SFD:  cur_nib = ncnt_q[0] ? 4'hD : 4'h5;
      ST_HDR:  cur_nib = ncnt_q[0] ? hdr_byte[7:4] : hdr_byte[3:0];
      ST_DATA: cur_nib = ncnt_q[0] ? hold_data[7:4] : hold_data[3:0];
      ST_FCS:  cur_nib = fcs_nib;
      default: cur_nib = 4'h0;
    endcase
  end

  assign mii_tx_en = sending && !abort_now;
  assign mii_txd   = mii_tx_en ? cur_nib : 4'h0;
  assign tx_err    = abort_now;

  mft_hdr_shift #(.BYTES(HDR_BYTES)) u_hdr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start_ok),
    .advance  ((state_q == ST_HDR) && ncnt_q[0]),
    .hdr      ({dst_mac, src_mac, len_type}),
    .cur_byte (hdr_byte)
  );

  mft_byte_hold u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (hold_clear),
    .accept_en (accept_en),
    .consume   (consume),
    .s_valid   (s_valid),
    .s_data    (s_data),
    .s_last    (s_last),
    .s_ready   (s_ready),
    .full      (hold_full),
    .data      (hold_data),
    .last      (hold_last)
  );

  mft_crc32 #(.POLY(CRC_POLY_REFL)) u_crc (
    .clk     (clk),
    .rst_n   (rst_n),
    .init    (start_ok),
    .step    (crc_step),
    .shift   (crc_shift),
    .nib     (cur_nib),
    .fcs_nib (fcs_nib)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ncnt_q  <= '0;
      dcnt_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q <= ST_PRE;
            ncnt_q  <= '0;
            dcnt_q  <= '0;
          end
        end
        ST_PRE: begin
          if (ncnt_q == PRE_END) begin
            state_q <= ST_SFD;
            ncnt_q  <= '0;
          end else ncnt_q <= ncnt_q + 1'b1;
        end
        ST_SFD: begin
          if (ncnt_q[0]) begin
            state_q <= ST_HDR;
            ncnt_q  <= '0;
          end else ncnt_q <= ncnt_q + 1'b1;
        end
        ST_HDR: begin
          if (ncnt_q == HDR_END) begin
            state_q <= ST_DATA;
            ncnt_q  <= '0;
          end else ncnt_q <= ncnt_q + 1'b1;
        end
        ST_DATA: begin
          if (abort_now) begin
            state_q <= ST_GAP;
            ncnt_q  <= '0;
          end else if (!ncnt_q[0]) begin
            ncnt_q <= ncnt_q + 1'b1;
          end else begin
            ncnt_q <= '0;
            dcnt_q <= dcnt_q + 1'b1;
            if (hold_last) state_q <= (dcnt_q < PAD_END) ? ST_PAD : ST_FCS;
          end
        end
        ST_PAD: begin
          if (!ncnt_q[0]) begin
            ncnt_q <= ncnt_q + 1'b1;
          end else begin
            ncnt_q <= '0;
            dcnt_q <= dcnt_q + 1'b1;
            if (dcnt_q == PAD_END) state_q <= ST_FCS;
          end
        end
        ST_FCS: begin
          if (ncnt_q == FCS_END) begin
            state_q <= ST_GAP;
            ncnt_q  <= '0;
          end else ncnt_q <= ncnt_q + 1'b1;
        end
        default: begin
          if (ncnt_q == GAP_END) begin
            state_q <= ST_IDLE;
            ncnt_q  <= '0;
          end else ncnt_q <= ncnt_q + 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/mft_checks.sv
module mft_checks #(
  parameter int IFG_NIB = 24
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       idle,
  input logic       s_ready,
  input logic [3:0] mii_txd,
  input logic       mii_tx_en,
  input logic       tx_err
);

  localparam int GW = $clog2(IFG_NIB + 1);

  logic [GW-1:0] quiet_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                           quiet_q <= GW'(IFG_NIB);
    else if (mii_tx_en)                   quiet_q <= '0;
    else if (quiet_q != GW'(IFG_NIB))     quiet_q <= quiet_q + 1'b1;
  end

  AST_ABORT_DROPS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    tx_err |-> !mii_tx_en);                                              // R7
  AST_FIRST_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mii_tx_en) |-> (mii_txd == 4'h5));                              // R2
  AST_START_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && start) |=> mii_tx_en);                                       // R2
  AST_READY_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !s_ready);                                                   // R4
  AST_QUIET_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mii_tx_en) |-> (quiet_q == GW'(IFG_NIB)));                      // R9
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> (!mii_tx_en && mii_txd == 4'h0));                            // R1

endmodule

bind mii_frame_tx mft_checks #(.IFG_NIB(IFG_NIB)) u_mft_checks (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .idle      (idle),
  .s_ready   (s_ready),
  .mii_txd   (mii_txd),
  .mii_tx_en (mii_tx_en),
  .tx_err    (tx_err)
);

// File: tb/mii_frame_tx_bench.sv
module mii_frame_tx_bench;

  localparam int CLK_PERIOD = 10;
  localparam int MIN_D = 46;
  localparam int MAX_D = 64;
  localparam int PRE_B = 7;
  localparam int IFG   = 24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [47:0] dst_mac = '0;
  logic [47:0] src_mac = '0;
  logic [15:0] len_type = '0;
  logic        idle;
  logic        s_valid = 1'b0;
  logic [7:0]  s_data = '0;
  logic        s_last = 1'b0;
  logic        s_ready;
  logic [3:0]  mii_txd;
  logic        mii_tx_en;
  logic        tx_err;

  int tests = 0;
  int fails = 0;
  logic [3:0] nib [0:1023];
  int  nib_cnt;
  bit  err_seen;
  bit  drv_stop;
  logic [7:0] pay [0:127];
  logic [7:0] exp_b [0:255];

  mii_frame_tx #(.MIN_DATA(MIN_D), .MAX_DATA(MAX_D), .PRE_BYTES(PRE_B), .IFG_NIB(IFG))
  u_mii_frame_tx (
    .clk(clk), .rst_n(rst_n), .start(start), .dst_mac(dst_mac), .src_mac(src_mac),
    .len_type(len_type), .idle(idle), .s_valid(s_valid), .s_data(s_data),
    .s_last(s_last), .s_ready(s_ready), .mii_txd(mii_txd), .mii_tx_en(mii_tx_en),
    .tx_err(tx_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: run hung (act=timeout exp=done)");
    summary();
    $finish;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(input int first, input int count);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < count; i++) begin
      c = c ^ {24'h0, exp_b[first+i]};
      for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return ~c;
  endfunction

  task automatic drive(input int n, input int gap_at);
    int i = 0;
    while (i < n && !drv_stop) begin
      @(negedge clk);
      if (i == gap_at) begin
        s_valid = 1'b0;
        repeat (6) @(negedge clk);
        gap_at = -1;
      end
      s_valid = 1'b1;
      s_data  = pay[i];
      s_last  = (i == n - 1);
      if (s_ready) begin
        @(posedge clk);
        i++;
      end
    end
    @(negedge clk);
    s_valid = 1'b0;
    s_last  = 1'b0;
  endtask

  task automatic collect(input int mid_at);
    int guard = 0;
    nib_cnt  = 0;
    err_seen = 0;
    while (!mii_tx_en && guard < 2000) begin @(negedge clk); guard++; end
    while (mii_tx_en) begin
      nib[nib_cnt] = mii_txd;
      nib_cnt++;
      if (mid_at > 0) start = (nib_cnt == mid_at);
      @(negedge clk);
      if (tx_err) err_seen = 1;
    end
    if (mid_at > 0) start = 1'b0;
    drv_stop = 1;
  endtask

  task automatic setup(input int n, input int seed);
    dst_mac  = 48'h0A1B2C3D4E5F ^ {40'h0, 8'(seed)};
    src_mac  = 48'h665544332211 + 48'(seed);
    len_type = 16'(n) ^ {8'(seed), 8'h00};
    for (int i = 0; i < 128; i++) pay[i] = 8'(i * 13 + seed);
  endtask

  task automatic wait_idle();
    int g = 0;
    while (!idle && g < 5000) begin @(negedge clk); g++; end
  endtask

  task automatic send(input int n, input int gap_at, input int mid_at);
    drv_stop = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    fork
      drive(n, gap_at);
      collect(mid_at);
    join
  endtask

  task automatic verify(input int n, input string tag);
    int dl = (n < MIN_D) ? MIN_D : n;
    int nb = PRE_B + 1 + 14 + dl + 4;
    int k = 0;
    bit ok;
    logic [31:0] f;
    logic [7:0] got;
    for (int i = 0; i < PRE_B; i++) exp_b[k++] = 8'h55;
    exp_b[k++] = 8'hD5;
    for (int i = 5; i >= 0; i--) exp_b[k++] = dst_mac[i*8 +: 8];
    for (int i = 5; i >= 0; i--) exp_b[k++] = src_mac[i*8 +: 8];
    exp_b[k++] = len_type[15:8];
    exp_b[k++] = len_type[7:0];
    for (int i = 0; i < dl; i++) exp_b[k++] = (i < n) ? pay[i] : 8'h00;
    f = ref_crc(PRE_B + 1, 14 + dl);
    for (int i = 0; i < 4; i++) exp_b[k++] = f[i*8 +: 8];
    check(nib_cnt == 2 * nb, {"R11 nibble count ", tag}, nib_cnt, 2 * nb);
    check(!err_seen, {"R7 no error ", tag}, err_seen, 0);
    if (nib_cnt == 2 * nb) begin
      for (int r = 0; r < 5; r++) begin
        int lo, hi;
        string rq;
        case (r)
          0: begin lo = 0; hi = PRE_B + 1; rq = "R2 preamble/delimiter"; end
          1: begin lo = PRE_B + 1; hi = PRE_B + 15; rq = "R3 header"; end
          2: begin lo = PRE_B + 15; hi = PRE_B + 15 + n; rq = "R4 payload"; end
          3: begin lo = PRE_B + 15 + n; hi = PRE_B + 15 + dl; rq = "R5 pad"; end
          default: begin lo = PRE_B + 15 + dl; hi = nb; rq = "R6 fcs"; end
        endcase
        if (hi > lo) begin
          ok = 1;
          for (int b = lo; b < hi; b++) begin
            got = {nib[2*b+1], nib[2*b]};
            if (ok && got != exp_b[b]) begin
              ok = 0;
              check(0, {rq, " ", tag}, got, exp_b[b]);
            end
          end
          if (ok) check(1, {rq, " ", tag}, 0, 0);
        end
      end
    end
  endtask

  task automatic t_reset();
    check(!mii_tx_en && mii_txd == 0, "R1 tx quiet after reset", {mii_tx_en, mii_txd}, 0);
    check(!s_ready && !tx_err, "R1 ready/err low after reset", {s_ready, tx_err}, 0);
    check(idle, "R1 idle after reset", idle, 1);
  endtask

  task automatic t_short();
    setup(10, 3); send(10, -1, 0); verify(10, "short"); wait_idle();
  endtask

  task automatic t_exact_min();
    setup(MIN_D, 9); send(MIN_D, -1, 0); verify(MIN_D, "exact min"); wait_idle();
  endtask

  task automatic t_stray_start();
    setup(60, 21); send(60, -1, 70); verify(60, "R10 stray start"); wait_idle();
  endtask

  task automatic t_max();
    setup(MAX_D, 33); send(MAX_D, -1, 0); verify(MAX_D, "at max"); wait_idle();
  endtask

  task automatic t_over();
    setup(70, 40); send(70, -1, 0);
    check(err_seen, "R7 oversize error pulse", err_seen, 1);
    check(nib_cnt == 2 * (PRE_B + 15 + MAX_D), "R7 oversize stops before fcs",
          nib_cnt, 2 * (PRE_B + 15 + MAX_D));
    wait_idle();
  endtask

  task automatic t_underrun();
    setup(30, 50); send(30, 20, 0);
    check(err_seen, "R8 underrun error pulse", err_seen, 1);
    check(nib_cnt == 2 * (PRE_B + 15 + 20), "R8 underrun stops at gap",
          nib_cnt, 2 * (PRE_B + 15 + 20));
    wait_idle();
    check(idle && !s_ready, "R4 ready closed when idle", {idle, s_ready}, 2'b10);
  endtask

  task automatic t_gap();
    int low = 1;
    setup(20, 61); send(20, -1, 0); verify(20, "gap first");
    start = 1'b1;
    while (!mii_tx_en && low < 500) begin @(negedge clk); if (!mii_tx_en) low++; end
    start = 1'b0;
    check(low == IFG + 1, "R9 interframe gap", low, IFG + 1);
    drv_stop = 0;
    fork
      drive(20, -1);
      collect(0);
    join
    verify(20, "R9 second frame");
    wait_idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_short();
    t_exact_min();
    t_stray_start();
    t_max();
    t_over();
    t_underrun();
    t_gap();
    summary();
    $finish;
  end

endmodule